// File: doc/BRIEF.md
# Banked Internal Data Memory Mapper

This block holds the 256-byte internal data RAM of a small 8-bit controller core and turns each of the core's operand references into one physical location. Four access kinds are handled. A register reference picks one of eight working registers inside the bank named by the two bank-select status bits. A direct reference names a byte by its 8-bit address. An indirect reference takes the target address from working register 0 or 1 of the current bank. A bit reference names one bit, either inside a 16-byte bit window in low RAM or inside a special-function register.

Bytes 00h–7Fh are shared by direct and indirect references. Bytes 80h–FFh have two meanings. A direct reference there goes out on the special-function-register (SFR) port. An indirect reference there reads or writes the upper 128 bytes of RAM. A bit write into RAM is a read-modify-write that changes only the named bit. A bit reference into SFR space is passed to the SFR port as a byte address plus a bit index. The SFR side then applies the write or returns the byte.

Requests arrive on a valid/ready channel. Reads return one byte on a valid/ready response channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and the consumer holds `rsp_ready` low. While `rsp_ready` is low, a waiting response keeps its value. Writes return nothing. The SFR port is a plain strobe with a same-cycle read return.

Top module: `idm_mapper`

## Requirements
- R1: After reset, every RAM byte reads 00h, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_mode`=0 (register) with register number n in `req_addr[2:0]` addresses RAM byte {000, `bank_sel`[1:0], n}. Bank 2, R3 is byte 13h, and bank 3, R7 is byte 1Fh.
- R3: `req_mode`=1 (direct) with an address below 80h reads and writes RAM. This is the same storage that register and indirect references reach.
- R4: `req_mode`=1 with an address of 80h or above asserts `sfr_valid` with `sfr_addr` equal to the address and `sfr_bit`=0. A read returns `sfr_rdata`. A write puts `req_wdata` on `sfr_wdata`, and the RAM byte at that address is left unchanged.
- R5: `req_mode`=2 (indirect) uses the byte in working register `req_addr[0]` (0 selects R0, 1 selects R1) of the current bank as a full 8-bit RAM address, which includes 80h–FFh. It never asserts `sfr_valid`.
- R6: `req_mode`=3 (bit) with a bit address b below 80h reaches bit b[2:0] of RAM byte 20h+b[6:3]. A write stores `req_wdata[0]` there and leaves the other seven bits unchanged. Bit 00h is bit 0 of 20h, and bit 7Fh is bit 7 of 2Fh.
- R7: `req_mode`=3 with b of 80h or above asserts `sfr_valid` with `sfr_bit`=1, `sfr_addr`={b[7:3],000} and `sfr_bit_idx`=b[2:0]. A write carries the bit value in `sfr_wdata[0]`. A read returns `sfr_rdata[b[2:0]]`.
- R8: A bit read returns the selected bit in `rsp_data[0]`, and `rsp_data[7:1]` is zero.
- R9: An accepted read raises `rsp_valid` on the next cycle. The response holds its value until `rsp_ready` is high. An accepted write produces no response. `req_ready` is high unless a response is waiting with `rsp_ready` low.
- R10: `sfr_valid` is asserted only in a cycle that accepts a direct or bit reference aimed at 80h or above. Register and indirect references never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_mode | input | 2 | 0 register, 1 direct, 2 indirect, 3 bit |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Register number, byte address, pointer select or bit address |
| req_wdata | input | 8 | Write byte; bit writes use bit 0 |
| bank_sel | input | 2 | Register bank select status bits |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read byte or selected bit in bit 0 |
| sfr_valid | output | 1 | SFR access strobe |
| sfr_write | output | 1 | SFR access is a write |
| sfr_bit | output | 1 | SFR access is a single-bit access |
| sfr_addr | output | 8 | SFR byte address |
| sfr_bit_idx | output | 3 | Bit index for bit access |
| sfr_wdata | output | 8 | SFR write byte, or bit value in bit 0 |
| sfr_rdata | input | 8 | SFR byte returned in the same cycle |

## Verification
Two events can coincide at the block's edge. The consumer can release a stalled read response in the same cycle that a new read, held back by the stall, is accepted. The bench provokes this by lowering `rsp_ready` after one read and keeping a second read waiting for several cycles. During those cycles it checks that `req_ready` stays low and the held byte does not move. It then raises `rsp_ready` while the second request is still pending. The scoreboard must then see the old byte and the new byte in order, with neither lost nor duplicated.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_DIR = 2'd1,
    MODE_IND = 2'd2,
    MODE_BIT = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic              to_sfr;
    logic              is_bit;
    logic [ADDR_W-1:0] byte_addr;
    logic [IDX_W-1:0]  bit_idx;
  } xlate_t;
endpackage

// File: rtl/idm_xlate.sv
module idm_xlate
  import idm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  acc_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bank,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_addr,
  output xlate_t            xl
);
  // working register of the current bank that holds the pointer
  assign ptr_addr = {3'b000, bank, 2'b00, addr[0]};

  always_comb begin
    xl = '0;
    unique case (mode)
      MODE_REG: xl.byte_addr = {3'b000, bank, addr[2:0]};
      MODE_DIR: begin
        xl.byte_addr = addr;
        xl.to_sfr    = addr[ADDR_W-1];
      end
      MODE_IND: xl.byte_addr = ptr;
      MODE_BIT: begin
        xl.is_bit  = 1'b1;
        xl.bit_idx = addr[IDX_W-1:0];
        if (addr[ADDR_W-1]) begin
          xl.to_sfr    = 1'b1;
          xl.byte_addr = {addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        end else begin
          xl.byte_addr = BIT_BASE + {4'b0000, addr[6:3]};
        end
      end
    endcase
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram
  import idm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ra_ptr,
  output logic [DATA_W-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] ra_tgt,
  output logic [DATA_W-1:0] rd_tgt,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd
);
  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_ptr = mem[ra_ptr];
  assign rd_tgt = mem[ra_tgt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end
endmodule

// File: rtl/idm_bitmerge.sv
module idm_bitmerge
  import idm_pkg::*;
(
  input  logic [DATA_W-1:0] old_byte,
  input  logic [IDX_W-1:0]  idx,
  input  logic              new_bit,
  output logic [DATA_W-1:0] merged,
  output logic              picked
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign merged[g] = (idx == IDX_W'(g)) ? new_bit : old_byte[g];
  end
  assign picked = old_byte[idx];
endmodule

// File: rtl/idm_mapper.sv
module idm_mapper
  import idm_pkg::*;
#(
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_mode,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [1:0] bank_sel,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       sfr_valid,
  output logic       sfr_write,
  output logic       sfr_bit,
  output logic [7:0] sfr_addr,
  output logic [2:0] sfr_bit_idx,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  logic              accept;
  logic [ADDR_W-1:0] ptr_addr;
  logic [DATA_W-1:0] ptr_byte;
  logic [DATA_W-1:0] ram_byte;
  logic [DATA_W-1:0] src_byte;
  logic [DATA_W-1:0] merged;
  logic              picked;
  logic              ram_we;
  xlate_t            xl;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  idm_xlate #(.BIT_BASE(BIT_BASE)) u_xlate (
    .mode     (acc_mode_e'(req_mode)),
    .addr     (req_addr),
    .bank     (bank_sel),
    .ptr      (ptr_byte),
    .ptr_addr (ptr_addr),
    .xl       (xl)
  );

  assign ram_we = accept && req_write && !xl.to_sfr;

  idm_ram u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_ptr (ptr_addr),
    .rd_ptr (ptr_byte),
    .ra_tgt (xl.byte_addr),
    .rd_tgt (ram_byte),
    .we     (ram_we),
    .wa     (xl.byte_addr),
    .wd     (xl.is_bit ? merged : req_wdata)
  );

  assign src_byte = xl.to_sfr ? sfr_rdata : ram_byte;

  idm_bitmerge u_merge (
    .old_byte (src_byte),
    .idx      (xl.bit_idx),
    .new_bit  (req_wdata[0]),
    .merged   (merged),
    .picked   (picked)
  );

  assign sfr_valid   = accept && xl.to_sfr;
  assign sfr_write   = req_write;
  assign sfr_bit     = xl.is_bit;
  assign sfr_addr    = xl.byte_addr;
  assign sfr_bit_idx = xl.bit_idx;
  assign sfr_wdata   = xl.is_bit ? {7'b0, req_wdata[0]} : req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= xl.is_bit ? {7'b0, picked} : src_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/idm_mapper_chk.sv
module idm_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_mode,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       sfr_valid,
  input logic       sfr_bit,
  input logic [7:0] sfr_addr,
  input logic [2:0] sfr_bit_idx
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_read_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);

  assert_write_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);

  assert_sfr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_valid |-> req_valid && req_ready && (req_mode == 2'd1 || req_mode == 2'd3));

  assert_sfr_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_valid && req_mode == 2'd1 |-> req_addr[7] && sfr_addr == req_addr && !sfr_bit);

  assert_direct_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 2'd1 && req_addr[7] |-> sfr_valid);

  assert_sfr_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_valid && req_mode == 2'd3 |->
      sfr_bit && sfr_addr == {req_addr[7:3], 3'b000} && sfr_bit_idx == req_addr[2:0]);

  assert_bit_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_mode == 2'd3 |=> rsp_data[7:1] == 7'd0);
endmodule

bind idm_mapper idm_mapper_chk u_chk (.*);

// File: tb/idm_mapper_test.sv
module idm_mapper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_mode = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] bank_sel = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       sfr_valid, sfr_write, sfr_bit;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic [2:0] sfr_bit_idx;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] sfr_mem [256];
  int         sfr_hits = 0;
  logic       snap_v, snap_w, snap_b;
  logic [7:0] snap_a, snap_d;
  logic [2:0] snap_i;
  logic [7:0] last_a, last_d;
  logic [2:0] last_i;
  logic       last_b;

  always #10 clk = ~clk;

  idm_mapper uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .bank_sel(bank_sel), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .sfr_valid(sfr_valid),
    .sfr_write(sfr_write), .sfr_bit(sfr_bit), .sfr_addr(sfr_addr),
    .sfr_bit_idx(sfr_bit_idx), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  assign sfr_rdata = sfr_mem[sfr_addr];

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // SFR side model: snapshot away from edges, apply at the edge
  always @(negedge clk) begin
    #2;
    snap_v = sfr_valid; snap_w = sfr_write; snap_b = sfr_bit;
    snap_a = sfr_addr;  snap_d = sfr_wdata; snap_i = sfr_bit_idx;
  end

  always @(posedge clk) begin
    if (rst_n && snap_v) begin
      sfr_hits++;
      last_a = snap_a; last_d = snap_d; last_i = snap_i; last_b = snap_b;
      if (snap_w) begin
        if (snap_b) sfr_mem[snap_a][snap_i] <= snap_d[0];
        else        sfr_mem[snap_a] <= snap_d;
      end
    end
  end

  // monitor: pops expected read responses
  always @(negedge clk) begin
    #3;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_data, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic send(input logic [1:0] mode, input bit wr, input logic [7:0] addr,
                      input logic [7:0] wd, input logic [7:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_write = wr; req_addr = addr; req_wdata = wd;
    if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] mode, input logic [7:0] addr, input logic [7:0] wd);
    send(mode, 1'b1, addr, wd, 8'h00, "");
  endtask

  task automatic rd(input logic [1:0] mode, input logic [7:0] addr, input logic [7:0] exp, input string tag);
    send(mode, 1'b0, addr, 8'h00, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 8'h00, 8'h01);
    summary();
  end

  initial begin
    int hits0;
    for (int i = 0; i < 256; i++) sfr_mem[i] = 8'(i ^ 8'h5A);
    sfr_mem[8'hC0] = 8'h99;
    sfr_mem[8'hD0] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", {7'b0, rsp_valid}, 8'h00);
    check(req_ready == 1'b1, "R1 req_ready", {7'b0, req_ready}, 8'h01);
    rd(2'd1, 8'h45, 8'h00, "R1 ram 45h cleared");
    rd(2'd1, 8'h7F, 8'h00, "R1 ram 7Fh cleared");

    // R2 register banks
    hits0 = sfr_hits;
    bank_sel = 2'd2;
    wr(2'd0, 8'h03, 8'hA5);
    check(rsp_valid == 1'b0, "R9 write silent", {7'b0, rsp_valid}, 8'h00);
    rd(2'd1, 8'h13, 8'hA5, "R2 bank2 R3 at 13h");
    bank_sel = 2'd0;
    rd(2'd0, 8'h03, 8'h00, "R2 bank0 R3 separate");
    bank_sel = 2'd3;
    wr(2'd0, 8'h07, 8'h3C);
    rd(2'd1, 8'h1F, 8'h3C, "R2 bank3 R7 at 1Fh");

    // R3 direct low RAM
    wr(2'd1, 8'h30, 8'h77);
    rd(2'd1, 8'h30, 8'h77, "R3 direct 30h");

    // R5 indirect through R1 of bank1 into upper RAM
    bank_sel = 2'd1;
    wr(2'd0, 8'h01, 8'hC0);
    wr(2'd2, 8'h01, 8'h5A);
    rd(2'd2, 8'h01, 8'h5A, "R5 indirect C0h via R1");
    bank_sel = 2'd0;
    wr(2'd1, 8'h01, 8'h30);
    rd(2'd2, 8'h01, 8'h77, "R5 bank0 R1 points to 30h");
    check(sfr_hits == hits0, "R10 no sfr for reg/indirect", 8'(sfr_hits - hits0), 8'h00);

    // R4 direct high goes to SFR port
    rd(2'd1, 8'hC0, 8'h99, "R4 direct C0h reads SFR");
    wr(2'd1, 8'h90, 8'hE1);
    check(last_a == 8'h90 && !last_b, "R4 sfr addr", last_a, 8'h90);
    check(sfr_mem[8'h90] == 8'hE1, "R4 sfr write data", sfr_mem[8'h90], 8'hE1);
    bank_sel = 2'd1;
    wr(2'd0, 8'h00, 8'h90);
    rd(2'd2, 8'h00, 8'h00, "R4 ram 90h untouched");

    // R6 / R8 RAM bit window
    wr(2'd1, 8'h25, 8'hF0);
    wr(2'd3, 8'h2B, 8'h01);
    rd(2'd1, 8'h25, 8'hF8, "R6 set bit 2Bh");
    wr(2'd3, 8'h2C, 8'h00);
    rd(2'd1, 8'h25, 8'hE8, "R6 clear bit 2Ch");
    rd(2'd3, 8'h2B, 8'h01, "R8 bit read 2Bh");
    rd(2'd3, 8'h2D, 8'h01, "R8 bit read 2Dh");
    rd(2'd3, 8'h2A, 8'h00, "R8 bit read 2Ah");
    wr(2'd3, 8'h00, 8'h01);
    rd(2'd1, 8'h20, 8'h01, "R6 bit 00h is 20h.0");
    wr(2'd3, 8'h7F, 8'hFF);
    rd(2'd1, 8'h2F, 8'h80, "R6 bit 7Fh is 2Fh.7");

    // R7 SFR bit access
    wr(2'd3, 8'hD3, 8'h01);
    check(last_b && last_a == 8'hD0 && last_i == 3'd3, "R7 sfr bit fields", last_a, 8'hD0);
    check(last_d == 8'h01, "R7 sfr bit value", last_d, 8'h01);
    check(sfr_mem[8'hD0] == 8'h08, "R7 sfr byte after bit write", sfr_mem[8'hD0], 8'h08);
    rd(2'd3, 8'hD3, 8'h01, "R7 sfr bit read D3h");
    rd(2'd3, 8'hD2, 8'h00, "R7 sfr bit read D2h");

    // R9 stall with a second read waiting
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(2'd1, 8'h30, 8'h77, "R9 stalled byte");
    req_valid = 1'b1; req_mode = 2'd1; req_write = 1'b0; req_addr = 8'h25;
    exp_q.push_back(8'hE8); tag_q.push_back("R9 byte after release");
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid && rsp_data == 8'h77, "R9 held response", rsp_data, 8'h77);
      check(req_ready == 1'b0, "R9 ready low while held", {7'b0, req_ready}, 8'h00);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses seen", 8'(exp_q.size()), 8'h00);
    summary();
  end
endmodule